// File: doc/BRIEF.md
# Cascadable Codec Serial Port Controller

This block is the device end of a full-duplex synchronous serial link between a multichannel sampling front end and a host processor. One 16-bit shift register carries both directions. While an outgoing word leaves on the serial output, most significant bit first, the incoming word enters at the least significant end. The device is always the master. A frame starts only when an output sample event arrives. The block then raises its frame-sync output for one bit time and clocks out sixteen bits. The host answers inside that same frame. Both the block clock and the serial bit clock are `clk`, so one cycle carries one bit.

Eight 8-bit control registers set the behaviour. Register 0 selects the port mode. Register 2 holds the enable for the reference output buffer. In program mode, incoming words write or read the registers. In data mode, the port only streams raw samples and ignores all input. In mixed mode, the top bit of each frame separates control words from samples, so samples are cut to 15 bits.

A control word that carries a nonzero device address is meant for a device further down a cascade. It is sent on in the next frame, with the address reduced by one. A read request is answered in the next frame. A new sample event always reloads the shared register, even in the middle of a frame, and the partly received word is then dropped.

Top module: `codec_sport`

## Requirements
- R1: After reset, `fs_out`, `ser_out` and `ref_buf_en` are low. The port is in program mode. All eight control registers read back as zero.
- R2: When `sample_valid` is high at a clock edge, `fs_out` is high for the next cycle only. Over the following 16 cycles the loaded word appears on `ser_out`, bit 15 first.
- R3: `ser_in` is sampled in those same 16 cycles, bit 15 first. The received word is acted on only if `fs_in` was high during the cycle in which `fs_out` was high.
- R4: A control word has this layout: bit 15 is the control flag, bit 14 is read (1) or write (0), bits 13:11 are the device address, bits 10:8 are the register index and bits 7:0 are the data. An accepted write with device address 0 stores the data byte in the indexed register.
- R5: An accepted read with device address 0 makes the next frame output the reply {1, 1, 000, index, register value}. In program mode, a frame with nothing pending outputs 0x0000.
- R6: An accepted word with a nonzero device address writes no register. The next frame outputs the same word with the device address reduced by one.
- R7: When register 0 bits [1:0] are 01 (data mode), each frame outputs the raw 16-bit sample. Every incoming word is ignored, and any pending word is discarded.
- R8: When register 0 bits [1:0] are 11 (mixed mode), a sample goes out as {0, sample[15:1]}. An incoming word with bit 15 at 0 is ignored. An incoming word with bit 15 at 1 is decoded as in R4 to R6. A pending word takes the place of the sample.
- R9: `ref_buf_en` equals bit 6 of control register 2.
- R10: A sample event during a frame restarts the frame: a new sync pulse, then a newly loaded word. The partly received word has no effect.
- R11: A pending reply or forwarded word is sent in exactly one frame and is then cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Output sample event; starts a frame |
| sample_word | input | 16 | Newest converter sample |
| ser_in | input | 1 | Serial data from the host or from the upstream device |
| fs_in | input | 1 | Frame sync in; marks the incoming word as valid |
| ser_out | output | 1 | Serial data out, MSB first |
| fs_out | output | 1 | One-cycle frame sync ahead of each outgoing word |
| ref_buf_en | output | 1 | Reference output buffer enable |

## Verification
The assertions assume the following about the inputs:
- The host raises `fs_in` only in the sync cycle.
- A sample event that arrives during a frame is meant as a restart.
- A sync pulse lasts one cycle unless another sample event comes in right behind it.

The stimulus follows these rules. Sample events are spaced at least eighteen cycles apart, except for one deliberate mid-frame restart. `fs_in` is driven only in the sync cycle, and its value is chosen at random. During the random phase, register 0 writes are kept out of data mode, because that mode cannot be left. Data mode is entered only in a final directed phase.

// File: rtl/ccsp_pkg.sv
package ccsp_pkg;

    localparam int WORD_W   = 16;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = $clog2(NUM_REGS);
    localparam int DEV_W    = 3;
    localparam int MODE_IDX = 0;
    localparam int REF_IDX  = 2;
    localparam int REF_BIT  = 6;

    typedef enum logic [1:0] {
        MODE_PROG  = 2'd0,
        MODE_DATA  = 2'd1,
        MODE_MIXED = 2'd2
    } port_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SYNC  = 2'd1,
        SEQ_SHIFT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              is_ctrl;
        logic              rd;
        logic [DEV_W-1:0]  dev;
        logic [ADDR_W-1:0] ra;
        logic [REG_W-1:0]  data;
    } ctrl_word_t;

    function automatic port_mode_e mode_of(input logic [REG_W-1:0] cfg);
        if (!cfg[0]) return MODE_PROG;
        if (!cfg[1]) return MODE_DATA;
        return MODE_MIXED;
    endfunction

    function automatic logic [WORD_W-1:0] tag_sample(input logic [WORD_W-1:0] s);
        return {1'b0, s[WORD_W-1:1]};
    endfunction

    function automatic ctrl_word_t make_reply(input logic [ADDR_W-1:0] ra,
                                              input logic [REG_W-1:0]  v);
        ctrl_word_t r;
        r.is_ctrl = 1'b1;
        r.rd      = 1'b1;
        r.dev     = '0;
        r.ra      = ra;
        r.data    = v;
        return r;
    endfunction

    function automatic ctrl_word_t pass_down(input ctrl_word_t w);
        ctrl_word_t r;
        r     = w;
        r.dev = w.dev - 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/ccsp_regfile.sv
module ccsp_regfile
    import ccsp_pkg::*;
#(
    parameter int N = NUM_REGS,
    parameter int W = REG_W,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  mode_q,
    output logic [W-1:0]  ref_q
);

    logic [W-1:0] mem [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata  = mem[raddr];
    assign mode_q = mem[MODE_IDX];
    assign ref_q  = mem[REF_IDX];

    // R4: registers change only through an accepted write
    assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(mode_q) && $stable(ref_q)));

endmodule

// File: rtl/ccsp_frame_seq.sv
module ccsp_frame_seq
    import ccsp_pkg::*;
#(
    parameter int BITS = WORD_W,
    localparam int CW = $clog2(BITS)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic fs_in,
    output logic load,
    output logic shift_en,
    output logic done,
    output logic fs_out,
    output logic word_ok
);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic          fs_cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            cnt    <= '0;
            fs_cap <= 1'b0;
        end else if (start) begin
            state  <= SEQ_SYNC;
            cnt    <= '0;
            fs_cap <= 1'b0;
        end else begin
            unique case (state)
                SEQ_SYNC: begin
                    state  <= SEQ_SHIFT;
                    cnt    <= '0;
                    fs_cap <= fs_in;
                end
                SEQ_SHIFT: begin
                    if (cnt == CW'(BITS - 1)) state <= SEQ_IDLE;
                    else                      cnt   <= cnt + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign load     = start;
    assign shift_en = (state == SEQ_SHIFT);
    assign done     = shift_en && (cnt == CW'(BITS - 1)) && !start;
    assign fs_out   = (state == SEQ_SYNC);
    assign word_ok  = fs_cap;

    assert_sync_after_event_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> fs_out);

    assert_sync_single_R2: assert property (@(posedge clk) disable iff (rst)
        (fs_out && !start) |=> (!fs_out && shift_en));

    assert_frame_ends_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> (!shift_en && !fs_out));

    assert_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (shift_en && start) |=> (fs_out && !word_ok));

endmodule

// File: rtl/ccsp_shifter.sv
module ccsp_shifter
    import ccsp_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift_en,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] rx_word
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)           sr <= '0;
        else if (load)     sr <= load_word;
        else if (shift_en) sr <= {sr[W-2:0], ser_in};
    end

    assign ser_out = shift_en & sr[W-1];
    assign rx_word = {sr[W-2:0], ser_in};

    // R2/R3: one position per bit time, MSB leaves first
    assert_shift_step_R3: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !load) |=> (sr[W-1:1] == $past(sr[W-2:0])));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (sr == $past(load_word)));

endmodule

// File: rtl/codec_sport.sv
module codec_sport
    import ccsp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_valid,
    input  logic [WORD_W-1:0] sample_word,
    input  logic              ser_in,
    input  logic              fs_in,
    output logic              ser_out,
    output logic              fs_out,
    output logic              ref_buf_en
);

    logic              load, shift_en, done, word_ok;
    logic [WORD_W-1:0] rx_word, tx_word;
    logic [REG_W-1:0]  mode_q, ref_q, rd_val;
    port_mode_e        mode;
    ctrl_word_t        cw;
    logic              accept, is_fwd, reg_we, rd_req;
    logic              pend_v;
    ctrl_word_t        pend;

    ccsp_frame_seq #(.BITS(WORD_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (sample_valid),
        .fs_in    (fs_in),
        .load     (load),
        .shift_en (shift_en),
        .done     (done),
        .fs_out   (fs_out),
        .word_ok  (word_ok)
    );

    ccsp_shifter #(.W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_word (tx_word),
        .shift_en  (shift_en),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .rx_word   (rx_word)
    );

    assign cw   = ctrl_word_t'(rx_word);
    assign mode = mode_of(mode_q);

    ccsp_regfile #(.N(NUM_REGS), .W(REG_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .waddr  (cw.ra),
        .wdata  (cw.data),
        .raddr  (cw.ra),
        .rdata  (rd_val),
        .mode_q (mode_q),
        .ref_q  (ref_q)
    );

    always_comb begin
        accept = done && word_ok && (mode != MODE_DATA) &&
                 ((mode == MODE_PROG) || cw.is_ctrl);
        is_fwd = accept && (cw.dev != '0);
        reg_we = accept && (cw.dev == '0) && !cw.rd;
        rd_req = accept && (cw.dev == '0) && cw.rd;
    end

    always_comb begin
        if (pend_v && mode != MODE_DATA) tx_word = WORD_W'(pend);
        else if (mode == MODE_DATA)      tx_word = sample_word;
        else if (mode == MODE_MIXED)     tx_word = tag_sample(sample_word);
        else                             tx_word = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend   <= '0;
        end else if (load) begin
            pend_v <= 1'b0;
        end else if (is_fwd) begin
            pend_v <= 1'b1;
            pend   <= pass_down(cw);
        end else if (rd_req) begin
            pend_v <= 1'b1;
            pend   <= make_reply(cw.ra, rd_val);
        end
    end

    assign ref_buf_en = ref_q[REF_BIT];

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ref_buf_en && !fs_out && !ser_out));

    assert_data_mode_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DATA) |-> !reg_we);

    assert_mixed_untagged_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (done && mode == MODE_MIXED && !rx_word[WORD_W-1]) |=> !pend_v);

    assert_pending_once_R11: assert property (@(posedge clk) disable iff (rst)
        load |=> !pend_v);

    assert_forward_no_write_R6: assert property (@(posedge clk) disable iff (rst)
        is_fwd |-> !reg_we);

endmodule

// File: tb/codec_sport_bench.sv
module codec_sport_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic [15:0] sample_word = '0;
    logic        ser_in = 1'b0;
    logic        fs_in = 1'b0;
    logic        ser_out, fs_out, ref_buf_en;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  m_regs [8];
    bit          m_pv;
    logic [15:0] m_pend;
    string       m_ptag;

    always #5 clk = ~clk;

    codec_sport u_codec_sport (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample_word  (sample_word),
        .ser_in       (ser_in),
        .fs_in        (fs_in),
        .ser_out      (ser_out),
        .fs_out       (fs_out),
        .ref_buf_en   (ref_buf_en)
    );

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cword(bit c, bit rd, int dev, int ra, logic [7:0] d);
        return {c, rd, 3'(dev), 3'(ra), d};
    endfunction

    function automatic int m_mode();
        if (!m_regs[0][0]) return 0;
        if (!m_regs[0][1]) return 1;
        return 2;
    endfunction

    task automatic exp_out(input logic [15:0] samp, output logic [15:0] e, output string tag);
        if (m_pv && m_mode() != 1) begin e = m_pend; tag = m_ptag; end
        else if (m_mode() == 1)    begin e = samp; tag = "R7"; end
        else if (m_mode() == 2)    begin e = {1'b0, samp[15:1]}; tag = "R8"; end
        else                       begin e = 16'h0000; tag = "R11"; end
        m_pv = 0;
    endtask

    task automatic m_decode(input logic [15:0] w);
        int dev;
        if (m_mode() == 1) return;
        if (m_mode() == 2 && !w[15]) return;
        dev = int'(w[13:11]);
        if (dev != 0) begin
            m_pv = 1; m_pend = {w[15:14], 3'(dev - 1), w[10:0]}; m_ptag = "R6";
        end else if (w[14]) begin
            m_pv = 1; m_pend = {2'b11, 3'b000, w[10:8], m_regs[w[10:8]]}; m_ptag = "R5";
        end else begin
            m_regs[w[10:8]] = w[7:0];
        end
    endtask

    task automatic run_frame(input logic [15:0] win, input bit fs, input logic [15:0] samp,
                             input int abort_at, input string tag_ovr);
        logic [15:0] e, got;
        string tag;
        exp_out(samp, e, tag);
        if (tag_ovr != "") tag = tag_ovr;
        @(negedge clk);
        check(ref_buf_en === m_regs[2][6], "R9", 16'(ref_buf_en), 16'(m_regs[2][6]));
        sample_valid = 1'b1; sample_word = samp; fs_in = 1'b0; ser_in = 1'b0;
        @(negedge clk);
        sample_valid = 1'b0; fs_in = fs;
        check(fs_out === 1'b1, "R2", 16'(fs_out), 16'd1);
        got = '0;
        for (int k = 0; k < 16; k++) begin
            if (k == abort_at) return;
            @(negedge clk);
            if (k == 0) check(fs_out === 1'b0, "R2", 16'(fs_out), 16'd0);
            fs_in = 1'b0; ser_in = win[15-k]; got[15-k] = ser_out;
        end
        check(got === e, tag, got, e);
        if (fs) m_decode(win);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 8; i++) m_regs[i] = '0;
        m_pv = 0; m_pend = '0; m_ptag = "";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(fs_out === 1'b0 && ser_out === 1'b0, "R1", {14'd0, fs_out, ser_out}, 16'd0);
        check(ref_buf_en === 1'b0, "R1", 16'(ref_buf_en), 16'd0);

        // R1/R5: read of register 3 after reset returns zero
        run_frame(cword(1, 1, 0, 3, 8'h00), 1, 16'h1234, 16, "R5");
        run_frame(16'h0000, 0, 16'h2222, 16, "R1");
        run_frame(16'h0000, 0, 16'h3333, 16, "R11");

        // R9: reference enable follows bit 6 of register 2
        run_frame(cword(1, 0, 0, 2, 8'h40), 1, 16'h0, 16, "");
        run_frame(cword(1, 0, 0, 2, 8'h3F), 1, 16'h0, 16, "");
        run_frame(cword(1, 0, 0, 2, 8'hC0), 1, 16'h0, 16, "");

        // R4: write then read back
        run_frame(cword(1, 0, 0, 4, 8'h5A), 1, 16'h0, 16, "");
        run_frame(cword(1, 1, 0, 4, 8'h00), 1, 16'h0, 16, "");
        run_frame(16'h0000, 0, 16'h0, 16, "R4");

        // R3: write without frame sync is ignored
        run_frame(cword(1, 0, 0, 4, 8'h11), 0, 16'h0, 16, "");
        run_frame(cword(1, 1, 0, 4, 8'h00), 1, 16'h0, 16, "");
        run_frame(16'h0000, 0, 16'h0, 16, "R3");

        // R6: forward with decremented address, then confirm no local write
        run_frame(cword(1, 0, 2, 4, 8'hEE), 1, 16'h0, 16, "");
        run_frame(cword(1, 1, 0, 4, 8'h00), 1, 16'h0, 16, "R6");
        run_frame(16'h0000, 0, 16'h0, 16, "R6");

        // R10: restart mid-frame, partial write to register 5 dropped
        run_frame(cword(1, 0, 0, 5, 8'hAA), 1, 16'h0, 5, "");
        run_frame(cword(1, 1, 0, 5, 8'h00), 1, 16'h0, 16, "R10");
        run_frame(16'h0000, 0, 16'h0, 16, "R10");

        // R8: mixed mode
        run_frame(cword(1, 0, 0, 0, 8'h03), 1, 16'h0, 16, "");
        run_frame(cword(0, 0, 0, 6, 8'h77), 1, 16'hBEEF, 16, "R8");
        run_frame(cword(1, 1, 0, 6, 8'h00), 1, 16'hFFFF, 16, "R8");
        run_frame(cword(1, 0, 0, 6, 8'h99), 1, 16'h8001, 16, "R8");
        run_frame(cword(1, 1, 0, 6, 8'h00), 1, 16'h4321, 16, "");
        run_frame(16'h0000, 0, 16'h0F0F, 16, "R8");

        // random phase in program and mixed modes
        for (int i = 0; i < 150; i++) begin
            int kind, dev, ra;
            bit rd, flag, fs;
            logic [7:0] d;
            kind = int'($urandom % 4);
            dev  = (kind == 0) ? 1 + int'($urandom % 7) : 0;
            rd   = (kind == 1);
            ra   = int'($urandom % 8);
            d    = 8'($urandom);
            if (ra == 0 && d[0]) d[1] = 1'b1;
            flag = ($urandom % 4) != 0;
            fs   = ($urandom % 5) != 0;
            run_frame(cword(flag, rd, dev, ra, d), fs, 16'($urandom), 16, "");
        end

        // R7: data mode, raw samples and ignored writes
        run_frame(cword(1, 0, 0, 0, 8'h01), 1, 16'h0, 16, "");
        run_frame(cword(1, 0, 0, 2, ~m_regs[2]), 1, 16'hA5C3, 16, "R7");
        run_frame(cword(1, 0, 0, 0, 8'h00), 1, 16'h7E81, 16, "R7");
        run_frame(16'hFFFF, 1, 16'h0001, 16, "R7");
        @(negedge clk);
        check(ref_buf_en === m_regs[2][6], "R7", 16'(ref_buf_en), 16'(m_regs[2][6]));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule